// File: doc/BRIEF.md
# Address Translation Cache with Access Rights

This block is a small, fully associative cache of page translations. It sits between a processor's address generation and its memory path. A 32-bit virtual address is split into a 20-bit virtual page number and a 12-bit byte offset, which gives 4 KiB pages. The page number, together with the address-space identifier of the running process, is compared against every stored entry at once.

On a match the block returns the physical address in the same cycle. The physical address is the stored frame number joined to the untouched offset. Alongside the match, it checks the access kind and the privilege of the requester against the rights stored in the entry, and raises a rights violation where needed. When nothing matches, it asks an external page walker for the entry. The walker later returns the entry through a fill port.

Entries are chosen for replacement by a binary-tree pseudo-LRU. Software can drop the entries of one page, or every entry, after it changes a page table.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `lk_paddr` equals the stored frame number in its upper bits and `lk_vaddr[11:0]` in its low 12 bits, in the same cycle as the lookup. No clock edge is needed.
- R2: A lookup hits only when a valid entry holds both the same page number (`lk_vaddr[31:12]`) and the same `lk_asid`. The same page under another identifier misses.
- R3: A lookup (`lk_valid`=1) with no matching entry drives `walk_req`=1 and `lk_hit`=0. With `lk_valid`=0, both outputs are 0.
- R4: A fill (`fill_valid`=1) is visible to lookups from the next cycle. A fill whose page and identifier are already stored rewrites that same slot and evicts nothing.
- R5: A lookup whose page and identifier equal those of a fill in the same cycle reports a miss.
- R6: A fill that matches no entry goes to the lowest-numbered invalid slot while one exists.
- R7: When all 16 slots are valid, a new fill replaces the slot chosen by a 15-node pseudo-LRU tree. Every fill and every hit marks its slot as most recent. At each node the walk goes to the half holding the older access.
- R8: `fill_perm` bit 0 grants read, bit 1 grants write and bit 2 grants execute. `lk_kind` 0 is a read, 1 is a write, 2 is an instruction fetch, and 3 is treated as a read. A hit whose kind is not granted raises `lk_fault`.
- R9: `fill_perm` bit 3 marks a page open to user mode. A hit with `lk_user`=1 on a page with that bit clear raises `lk_fault`. Supervisor accesses (`lk_user`=0) ignore bit 3.
- R10: `lk_fault` is only ever high together with `lk_hit`. A miss never faults.
- R11: `inv_one` removes, from the next cycle, every entry whose page number equals `inv_vpn`, whatever its identifier.
- R12: `inv_all` removes every entry from the next cycle. A fill in the same cycle as an invalidation is kept.
- R13: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_user | input | 1 | 1 for a user-mode access |
| lk_hit | output | 1 | Translation found |
| lk_fault | output | 1 | Rights violation on the hit |
| lk_paddr | output | 32 | Physical address, zero when no hit |
| walk_req | output | 1 | Miss: page walk wanted |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_asid | input | 8 | Identifier of the new entry |
| fill_ppn | input | 20 | Frame number of the new entry |
| fill_perm | input | 4 | Rights: bit0 read, bit1 write, bit2 execute, bit3 user |
| inv_one | input | 1 | Drop entries of `inv_vpn` |
| inv_all | input | 1 | Drop all entries |
| inv_vpn | input | 20 | Page to drop |

## Verification
The assertions assume that a fill and a hit are never used to update the replacement tree in the same cycle. They also assume that the walker never returns a page that another slot already holds under a different slot number. Because fills are matched against stored entries first, repeated fills of one page stay legal.

The stimulus keeps every lookup out of fill cycles, except in the one same-cycle collision case. It drives the invalidation controls only in cycles without a lookup. This lets a bench-side table of slots and tree bits predict each hit, fault, address and eviction exactly.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef struct packed {
        logic usr;
        logic exe;
        logic wr;
        logic rd;
    } rights_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/xlat_rights_chk.sv
module xlat_rights_chk
    import xlat_pkg::*;
(
    input  rights_t    rights,
    input  logic [1:0] kind,
    input  logic       user,
    output logic       violation
);
    logic granted;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_STORE: granted = rights.wr;
            ACC_FETCH: granted = rights.exe;
            default:   granted = rights.rd;
        endcase
        violation = !granted || (user && !rights.usr);
    end
endmodule

// File: rtl/xlat_plru.sv
module xlat_plru #(
    parameter int WAYS  = 16,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim
);
    localparam int NODES = WAYS - 1;

    typedef struct packed {
        logic [NODES-1:0] tree;
    } plru_state_t;

    plru_state_t st_d, st_q;

    always_comb begin
        int node;
        st_d   = st_q;
        victim = '0;
        node   = 0;
        for (int lv = 0; lv < IDX_W; lv++) begin
            victim[IDX_W-1-lv] = st_q.tree[node];
            node = 2 * node + 1 + int'(st_q.tree[node]);
        end
        if (touch_en) begin
            node = 0;
            for (int lv = 0; lv < IDX_W; lv++) begin
                st_d.tree[node] = !touch_idx[IDX_W-1-lv];
                node = 2 * node + 1 + int'(touch_idx[IDX_W-1-lv]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xlat_slot_array.sv
module xlat_slot_array
    import xlat_pkg::*;
#(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N-1:0]      lk_match,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    output logic [N-1:0]      fl_match,
    output logic [N-1:0]      valid_o,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PPN_W-1:0]  rd_ppn,
    output rights_t           rd_rights,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  rights_t           wr_rights,
    input  logic              inv_one,
    input  logic              inv_all,
    input  logic [VPN_W-1:0]  inv_vpn
);
    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0][VPN_W-1:0]  vpn;
        logic [N-1:0][ASID_W-1:0] asid;
        logic [N-1:0][PPN_W-1:0]  ppn;
        rights_t [N-1:0]          rights;
    } slots_t;

    slots_t sl_d, sl_q;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign lk_match[g] = sl_q.valid[g] && (sl_q.vpn[g] == lk_vpn)
                             && (sl_q.asid[g] == lk_asid);
        assign fl_match[g] = sl_q.valid[g] && (sl_q.vpn[g] == fl_vpn)
                             && (sl_q.asid[g] == fl_asid);
    end

    assign valid_o   = sl_q.valid;
    assign rd_ppn    = sl_q.ppn[rd_idx];
    assign rd_rights = sl_q.rights[rd_idx];

    always_comb begin
        sl_d = sl_q;
        if (inv_all) begin
            sl_d.valid = '0;
        end else if (inv_one) begin
            for (int i = 0; i < N; i++) begin
                if (sl_q.vpn[i] == inv_vpn) sl_d.valid[i] = 1'b0;
            end
        end
        if (wr_en) begin
            sl_d.valid[wr_idx]  = 1'b1;
            sl_d.vpn[wr_idx]    = fl_vpn;
            sl_d.asid[wr_idx]   = fl_asid;
            sl_d.ppn[wr_idx]    = wr_ppn;
            sl_d.rights[wr_idx] = wr_rights;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 16,
    parameter int ASID_W    = 8,
    parameter int VPN_W     = VA_W - PAGE_BITS,
    parameter int PPN_W     = PA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_kind,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              walk_req,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [3:0]        fill_perm,
    input  logic              inv_one,
    input  logic              inv_all,
    input  logic [VPN_W-1:0]  inv_vpn
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_match, fl_match, slot_valid;
    logic [IDX_W-1:0]   hit_idx, fill_idx, lru_victim, free_idx, same_idx;
    logic [PPN_W-1:0]   hit_ppn;
    rights_t            hit_rights;
    logic               collide, matched, rights_bad, any_free, touch_en;
    logic [IDX_W-1:0]   touch_idx;

    assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

    xlat_slot_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_match(lk_match),
        .fl_vpn(fill_vpn), .fl_asid(fill_asid), .fl_match(fl_match),
        .valid_o(slot_valid),
        .rd_idx(hit_idx), .rd_ppn(hit_ppn), .rd_rights(hit_rights),
        .wr_en(fill_valid), .wr_idx(fill_idx), .wr_ppn(fill_ppn),
        .wr_rights(rights_t'(fill_perm)),
        .inv_one(inv_one), .inv_all(inv_all), .inv_vpn(inv_vpn)
    );

    xlat_rights_chk u_rights (
        .rights(hit_rights), .kind(lk_kind), .user(lk_user),
        .violation(rights_bad)
    );

    xlat_plru #(.WAYS(ENTRIES)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx), .victim(lru_victim)
    );

    always_comb begin
        hit_idx  = '0;
        same_idx = '0;
        free_idx = '0;
        any_free = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) hit_idx  = IDX_W'(i);
            if (fl_match[i]) same_idx = IDX_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        if (|fl_match)    fill_idx = same_idx;
        else if (any_free) fill_idx = free_idx;
        else              fill_idx = lru_victim;
    end

    assign collide  = fill_valid && (fill_vpn == lk_vpn) && (fill_asid == lk_asid);
    assign matched  = lk_valid && (|lk_match) && !collide;
    assign lk_hit   = matched;
    assign walk_req = lk_valid && !matched;
    assign lk_fault = matched && rights_bad;
    assign lk_paddr = matched ? {hit_ppn, lk_vaddr[PAGE_BITS-1:0]} : '0;

    assign touch_en  = fill_valid || matched;
    assign touch_idx = fill_valid ? fill_idx : hit_idx;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int VPN_W     = VA_W - PAGE_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic              lk_fault,
    input logic [PA_W-1:0]   lk_paddr,
    input logic              walk_req,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic              inv_one,
    input logic              inv_all
);
    assert_fault_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    assert_hit_or_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != walk_req));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !walk_req));

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

    assert_collide_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && fill_valid && lk_vaddr[VA_W-1:PAGE_BITS] == fill_vpn
         && lk_asid == fill_asid) |-> !lk_hit);

    assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fill_valid) |=> !lk_hit);

    assert_fill_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_one && !inv_all) |=>
        (!(lk_valid && lk_vaddr[VA_W-1:PAGE_BITS] == $past(fill_vpn)
           && lk_asid == $past(fill_asid)
           && !(fill_valid && fill_vpn == $past(fill_vpn) && fill_asid == $past(fill_asid)))
         || lk_hit));
endmodule

bind xlat_cache xlat_cache_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ASID_W(ASID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .lk_paddr(lk_paddr), .walk_req(walk_req), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .inv_one(inv_one),
    .inv_all(inv_all)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_fault, walk_req;
    logic [31:0] lk_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_perm = '0;
    logic        inv_one = 1'b0;
    logic        inv_all = 1'b0;
    logic [19:0] inv_vpn = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xlat_cache u0 (.*);

    // bench model of the slots and replacement tree
    logic        m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [7:0]  m_asid  [N];
    logic [19:0] m_ppn   [N];
    logic [3:0]  m_perm  [N];
    logic [14:0] m_tree;

    function automatic void m_touch(int idx);
        int node = 0;
        for (int lv = 3; lv >= 0; lv--) begin
            int b = (idx >> lv) & 1;
            m_tree[node] = (b == 0);
            node = 2 * node + 1 + b;
        end
    endfunction

    function automatic int m_victim();
        int node = 0;
        int v = 0;
        for (int lv = 0; lv < 4; lv++) begin
            int b = int'(m_tree[node]);
            v = v * 2 + b;
            node = 2 * node + 1 + b;
        end
        return v;
    endfunction

    function automatic int m_find(logic [19:0] vpn, logic [7:0] asid);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    task automatic fail_line(string req, string what, longint act, longint exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    task automatic look(logic [19:0] vpn, logic [11:0] off, logic [7:0] asid,
                        logic [1:0] kind, logic usr, string req);
        int idx;
        logic need, e_fault;
        logic [31:0] e_pa;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_asid = asid;
        lk_kind = kind; lk_user = usr;
        #1;
        idx = m_find(vpn, asid);
        checks++;
        if (idx < 0) begin
            if (lk_hit !== 1'b0 || walk_req !== 1'b1 || lk_fault !== 1'b0)
                fail_line(req, "miss hit/walk/fault", {lk_hit, walk_req, lk_fault}, 3'b010);
        end else begin
            case (kind)
                2'd1: need = m_perm[idx][1];
                2'd2: need = m_perm[idx][2];
                default: need = m_perm[idx][0];
            endcase
            e_fault = !need || (usr && !m_perm[idx][3]);
            e_pa = {m_ppn[idx], off};
            if (lk_hit !== 1'b1 || walk_req !== 1'b0 || lk_fault !== e_fault)
                fail_line(req, "hit hit/walk/fault", {lk_hit, walk_req, lk_fault},
                          {2'b10, e_fault});
            else if (lk_paddr !== e_pa)
                fail_line(req, "paddr", lk_paddr, e_pa);
        end
        @(posedge clk);
        if (idx >= 0) m_touch(idx);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn, logic [3:0] perm);
        int idx;
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn; fill_perm = perm;
        idx = m_find(vpn, asid);
        if (idx < 0) begin
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
        end
        if (idx < 0) idx = m_victim();
        @(posedge clk);
        m_valid[idx] = 1'b1; m_vpn[idx] = vpn; m_asid[idx] = asid;
        m_ppn[idx] = ppn; m_perm[idx] = perm;
        m_touch(idx);
        #1 fill_valid = 1'b0;
    endtask

    task automatic inval(logic one, logic all, logic [19:0] vpn);
        @(negedge clk);
        inv_one = one; inv_all = all; inv_vpn = vpn;
        @(posedge clk);
        for (int i = 0; i < N; i++)
            if (all || (one && m_vpn[i] == vpn)) m_valid[i] = 1'b0;
        #1 begin inv_one = 1'b0; inv_all = 1'b0; end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
        end
        m_tree = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R13 R3: empty after reset
        look(20'h00100, 12'h000, 8'd3, 2'd0, 1'b0, "R13");
        look(20'h00000, 12'hfff, 8'd0, 2'd2, 1'b1, "R3");

        // R6 R1: fill all slots in order, sweep offsets
        for (int i = 0; i < N; i++)
            fill(20'h00100 + 20'(i), 8'd3, 20'h05000 + 20'(i * 7), 4'hF);
        for (int i = 0; i < N; i++)
            look(20'h00100 + 20'(i), 12'(i * 257 + 3), 8'd3, 2'd0, 1'b0, "R1");

        // R2: other identifier misses
        for (int a = 0; a < 8; a++)
            look(20'h00105, 12'h0, 8'(a * 5 + 4), 2'd0, 1'b0, "R2");

        // R6: freed slot is reused, nothing else evicted
        inval(1'b1, 1'b0, 20'h00109);
        fill(20'h00200, 8'd3, 20'h0abcd, 4'hF);
        for (int i = 0; i < N; i++)
            look(20'h00100 + 20'(i), 12'h010, 8'd3, 2'd0, 1'b0, "R6");
        look(20'h00200, 12'h123, 8'd3, 2'd0, 1'b0, "R6");

        // R4 R8 R9 R10: rewrite one page with every rights value
        for (int p = 0; p < 16; p++) begin
            fill(20'h00103, 8'd3, 20'h07700 + 20'(p), 4'(p));
            for (int k = 0; k < 4; k++)
                for (int u = 0; u < 2; u++)
                    look(20'h00103, 12'h044, 8'd3, 2'(k), 1'(u), "R8_R9_R10");
        end
        for (int i = 0; i < N; i++)
            look(20'h00100 + 20'(i), 12'h000, 8'd3, 2'd0, 1'b0, "R4");

        // R7: evictions under several access orders
        for (int r = 0; r < 5; r++) begin
            look(20'h00100 + 20'((r * 5) % 16), 12'h0, 8'd3, 2'd0, 1'b0, "R7");
            look(20'h00100 + 20'((r * 11 + 2) % 16), 12'h0, 8'd3, 2'd0, 1'b0, "R7");
            fill(20'h00300 + 20'(r), 8'd3, 20'h0e000 + 20'(r), 4'hF);
            for (int i = 0; i < N; i++)
                look(20'h00100 + 20'(i), 12'h0, 8'd3, 2'd0, 1'b0, "R7");
            for (int j = 0; j <= r; j++)
                look(20'h00300 + 20'(j), 12'h0, 8'd3, 2'd0, 1'b0, "R7");
        end

        // R5: lookup collides with fill of the same page
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h00400; fill_asid = 8'd9;
        fill_ppn = 20'h01111; fill_perm = 4'hF;
        lk_valid = 1'b1; lk_vaddr = {20'h00400, 12'h020}; lk_asid = 8'd9;
        lk_kind = 2'd0; lk_user = 1'b0;
        #1 checks++;
        if (lk_hit !== 1'b0 || walk_req !== 1'b1)
            fail_line("R5", "collide hit/walk", {lk_hit, walk_req}, 2'b01);
        begin
            int idx = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
            if (idx < 0) idx = m_victim();
            @(posedge clk);
            m_valid[idx] = 1; m_vpn[idx] = 20'h00400; m_asid[idx] = 8'd9;
            m_ppn[idx] = 20'h01111; m_perm[idx] = 4'hF; m_touch(idx);
        end
        #1 begin fill_valid = 1'b0; lk_valid = 1'b0; end
        look(20'h00400, 12'h020, 8'd9, 2'd0, 1'b0, "R5");

        // R11: single-page drop covers all identifiers
        fill(20'h00500, 8'd1, 20'h02001, 4'hF);
        fill(20'h00500, 8'd2, 20'h02002, 4'hF);
        look(20'h00500, 12'h0, 8'd1, 2'd0, 1'b0, "R11");
        look(20'h00500, 12'h0, 8'd2, 2'd0, 1'b0, "R11");
        inval(1'b1, 1'b0, 20'h00500);
        look(20'h00500, 12'h0, 8'd1, 2'd0, 1'b0, "R11");
        look(20'h00500, 12'h0, 8'd2, 2'd0, 1'b0, "R11");
        look(20'h00400, 12'h0, 8'd9, 2'd0, 1'b0, "R11");

        // R12: full drop
        inval(1'b0, 1'b1, 20'h0);
        for (int i = 0; i < N; i++)
            look(20'h00100 + 20'(i), 12'h0, 8'd3, 2'd0, 1'b0, "R12");
        look(20'h00400, 12'h0, 8'd9, 2'd0, 1'b0, "R12");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule